// File: doc/BRIEF.md
# GPIO Register Bank with Polarity Inversion

This block is the register and pin-muxing core of a bidirectional general-purpose port. A bus front end, such as a serial slave controller, reaches it through four registers. It uses a two-bit register select, a single-cycle write strobe and a combinational read path. The four registers are:

- an input view of the pins
- a stored output value
- a per-bit read inversion mask
- a per-bit direction mask

The block drives a per-pin output enable and a per-pin output value toward the pad ring. It takes the raw pin levels back through a multi-stage synchronizer. Pad electronics, pull-ups and drive strength stay outside it.

All pins come out of reset as inputs. A pin becomes a driven output only when its direction bit is cleared. The input view always shows the synchronized pin level, XORed with the inversion mask, for every pin whatever its direction. A read of the output register returns the stored flop contents, never the pin level.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output register reads 8'hFF, the inversion mask reads 8'h00, the direction register reads 8'hFF, and both `pin_oe` and `pin_out` are all zeros.
- R2: A read with `reg_addr` = 2'd0 returns the synchronized pin levels XORed bit by bit with the inversion mask.
- R3: A write strobe with `reg_addr` = 2'd0 changes no register. Afterwards the output, inversion and direction registers, the input read value and the pin outputs are all unchanged.
- R4: A write with `reg_addr` = 2'd1 loads the output register. Reading address 2'd1 returns the stored value even when the pins carry different levels.
- R5: A write with `reg_addr` = 2'd2 loads the inversion mask. A 1 bit inverts that bit of the input read value, and a 0 bit passes it unchanged.
- R6: A write with `reg_addr` = 2'd3 loads the direction register. A 1 bit makes the pin an input, with `pin_oe` low and `pin_out` low. A 0 bit sets `pin_oe` high and drives `pin_out` from the output register bit.
- R7: The input read value follows the pin level for pins set as outputs, and ignores the output register contents.
- R8: A write to the output register appears on `pin_out` at the first clock edge after the strobe cycle. While the strobe is high, `pin_out` still shows the old value.
- R9: A change on `pin_in` reaches the input read value after exactly two clock edges. It has not yet appeared after one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select for both read and write |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `reg_addr` |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_out | output | 8 | Output value per pin, zero when the pin is an input |
| pin_oe | output | 8 | Output enable per pin, high when driving |

## Verification
The bench builds the block with its defaults: an 8-bit port and two synchronizer stages. With 8 bits, patterns such as 8'hA5 and 8'h3C can give different values to the pin levels, the output flops, the inversion mask and the direction mask in every nibble. One read can therefore tell a pin-sourced bit from a flop-sourced bit. With two stages, the bench can see a pin change still absent after one edge and present after the second. This covers the exact input latency and the one-edge output latency.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the GPIO register bank.
// Assumes a two-bit register select; register codes are fixed by the bus map.
package gpio_bank_pkg;
    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_PINS   = 2'd0,
        REG_DRIVE  = 2'd1,
        REG_INVERT = 2'd2,
        REG_DIR    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
// Multi-stage synchronizer for the raw pin levels.
// Assumes pins are asynchronous to clk; the stage count is a parameter (>= 2).
module gpio_pin_sync #(
    parameter int              WIDTH     = 8,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One flop stage of the chain; stage 0 captures the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[g] <= RESET_VAL;
                else if (g == 0)
                    stage_q[g] <= async_in;
                else
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_reg_file.sv
// Holds the writable registers: output value, inversion mask, direction.
// Assumes one write strobe per cycle; address 0 (pin view) is read-only.
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  reg_sel_e         wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] drive_q,
    output logic [WIDTH-1:0] invert_q,
    output logic [WIDTH-1:0] dir_q
);
    // Load the output register; resets to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drive_q <= '1;
        else if (wr_stb && wr_sel == REG_DRIVE)
            drive_q <= wr_data;
    end

    // Load the inversion mask; resets to pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n)
            invert_q <= '0;
        else if (wr_stb && wr_sel == REG_INVERT)
            invert_q <= wr_data;
    end

    // Load the direction register; resets to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '1;
        else if (wr_stb && wr_sel == REG_DIR)
            dir_q <= wr_data;
    end

    // R4: an output-register write is held in the flop.
    p_drive_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel == REG_DRIVE) |=> (drive_q == $past(wr_data)));

    // R5: an inversion write is held in the mask.
    p_invert_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel == REG_INVERT) |=> (invert_q == $past(wr_data)));

    // R3: a write to the read-only address disturbs no register.
    p_ro_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel == REG_PINS) |=>
            ($stable(drive_q) && $stable(invert_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_port_drive.sv
// Per-pin output enable and output value from direction and output registers.
// Assumes direction bit 1 = input (driver off, value forced low).
module gpio_port_drive #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] drive_q,
    input  logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_pin
            // Enable the driver only for output pins and gate the value to match.
            always_comb begin
                pin_oe[b]  = ~dir_q[b];
                pin_out[b] = dir_q[b] ? 1'b0 : drive_q[b];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_read_mux.sv
// Combinational read path: selects a register; the pin view is XORed with the mask.
// Assumes the pin view is already synchronized.
module gpio_read_mux
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  reg_sel_e         rd_sel,
    input  logic [WIDTH-1:0] pins_sync,
    input  logic [WIDTH-1:0] drive_q,
    input  logic [WIDTH-1:0] invert_q,
    input  logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] rd_data
);
    // Pick the addressed register for the bus.
    always_comb begin
        unique case (rd_sel)
            REG_PINS:   rd_data = pins_sync ^ invert_q;
            REG_DRIVE:  rd_data = drive_q;
            REG_INVERT: rd_data = invert_q;
            REG_DIR:    rd_data = dir_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank.sv
// Top of the GPIO register bank: synchronizer, register file, read mux and pin drive.
// Assumes a single clock domain for the register bus; pins may be asynchronous.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  wr_stb,
    input  logic [WIDTH-1:0]      wr_data,
    output logic [WIDTH-1:0]      rd_data,
    input  logic [WIDTH-1:0]      pin_in,
    output logic [WIDTH-1:0]      pin_out,
    output logic [WIDTH-1:0]      pin_oe
);
    localparam logic [WIDTH-1:0] PIN_IDLE = '1;

    reg_sel_e         sel;
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] drive_q;
    logic [WIDTH-1:0] invert_q;
    logic [WIDTH-1:0] dir_q;

    assign sel = reg_sel_e'(reg_addr);

    gpio_pin_sync #(
        .WIDTH(WIDTH), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pins_sync)
    );

    gpio_reg_file #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(sel),
        .wr_data(wr_data), .drive_q(drive_q), .invert_q(invert_q), .dir_q(dir_q)
    );

    gpio_read_mux #(.WIDTH(WIDTH)) u_rdmux (
        .rd_sel(sel), .pins_sync(pins_sync), .drive_q(drive_q),
        .invert_q(invert_q), .dir_q(dir_q), .rd_data(rd_data)
    );

    gpio_port_drive #(.WIDTH(WIDTH)) u_drive (
        .drive_q(drive_q), .dir_q(dir_q), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // R6: a direction write sets the enables to its complement on the next edge.
    p_dir_to_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sel == REG_DIR) |=> (pin_oe == ~$past(wr_data)));

    // R6: a pin without an enable never shows a driven one.
    p_input_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

    // R8: an output write reaches enabled pins one edge after the strobe.
    p_out_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sel == REG_DRIVE && !$isunknown(wr_data)) |=>
            (pin_out == ($past(wr_data) & pin_oe)));
endmodule

// File: tb/gpio_bank_bench.sv
// Scoreboard bench: driver tasks queue expectations, a negedge monitor checks them.
module gpio_bank_bench;
    localparam int W = 8;

    typedef struct {
        int          what;   // 0 rd_data, 1 pin_out, 2 pin_oe
        logic [W-1:0] exp;
        string       req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic         wr_stb = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic [W-1:0] pin_in = 8'hFF;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;

    item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gpio_bank #(.WIDTH(W), .SYNC_STAGES(2)) u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Monitor: compare every queued expectation against the outputs at negedge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [W-1:0] act;
            it = sb_q.pop_front();
            act = (it.what == 0) ? rd_data : (it.what == 1) ? pin_out : pin_oe;
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.what, act, it.exp);
            end
        end
    end

    task automatic expect_now(input int what, input logic [W-1:0] exp, input string req);
        item_t it;
        it.what = what; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [1:0] a, input logic [W-1:0] exp, input string req);
        step();
        reg_addr = a;
        expect_now(0, exp, req);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        step();
        reg_addr = a; wr_data = d; wr_stb = 1'b1;
        step();
        wr_stb = 1'b0;
    endtask

    // Change the pins and check the two-edge synchronizer latency (R9).
    task automatic set_pins(input logic [W-1:0] v, input logic [W-1:0] old_rd,
                            input logic [W-1:0] new_rd);
        step();
        pin_in = v; reg_addr = 2'd0;
        expect_now(0, old_rd, "R9 before edges");
        step();
        expect_now(0, old_rd, "R9 after one edge");
        step();
        expect_now(0, new_rd, "R9 after two edges");
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd1, 8'hFF, "R1 output reg");
        rd(2'd2, 8'h00, "R1 inversion");
        rd(2'd3, 8'hFF, "R1 direction");
        expect_now(1, 8'h00, "R1 pin_out");
        expect_now(2, 8'h00, "R1 pin_oe");
        rd(2'd0, 8'hFF, "R2 idle pins");
        // R2/R9 pin view
        set_pins(8'hA5, 8'hFF, 8'hA5);
        // R5 inversion
        wr(2'd2, 8'h0F);
        rd(2'd2, 8'h0F, "R5 mask readback");
        rd(2'd0, 8'hAA, "R5 inverted low nibble");
        // R3 write to read-only address
        wr(2'd0, 8'h00);
        rd(2'd0, 8'hAA, "R3 pin view unchanged");
        rd(2'd1, 8'hFF, "R3 output reg unchanged");
        rd(2'd2, 8'h0F, "R3 mask unchanged");
        rd(2'd3, 8'hFF, "R3 direction unchanged");
        // R4/R6 output reg while all inputs
        wr(2'd1, 8'h3C);
        rd(2'd1, 8'h3C, "R4 output readback");
        expect_now(1, 8'h00, "R6 inputs not driven");
        expect_now(2, 8'h00, "R6 no enables");
        // R6 low nibble as outputs
        wr(2'd3, 8'hF0);
        rd(2'd3, 8'hF0, "R6 direction readback");
        expect_now(2, 8'h0F, "R6 enables");
        expect_now(1, 8'h0C, "R6 driven low nibble");
        rd(2'd0, 8'hAA, "R7 pin view ignores output reg");
        rd(2'd1, 8'h3C, "R4 flop not pin");
        // R8 output latency
        step();
        reg_addr = 2'd1; wr_data = 8'hC3; wr_stb = 1'b1;
        expect_now(1, 8'h0C, "R8 old value during strobe");
        step();
        wr_stb = 1'b0;
        expect_now(1, 8'h03, "R8 new value after edge");
        // R2 plain pass-through, R7 with all outputs
        wr(2'd2, 8'h00);
        set_pins(8'h5A, 8'hA5, 8'h5A);
        wr(2'd3, 8'h00);
        expect_now(2, 8'hFF, "R6 all enabled");
        expect_now(1, 8'hC3, "R6 all driven");
        rd(2'd0, 8'h5A, "R7 all-output pins read");
        wr(2'd0, 8'hFF);
        expect_now(1, 8'hC3, "R3 pin_out unchanged");
        rd(2'd0, 8'h5A, "R3 pin view unchanged");
        step();
        step();
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule